// File: doc/BRIEF.md
# Reset Strap Capture and Configuration

This block gives the rest of the device its boot-time configuration. Configuration pins are read once, on the clock edge where a properly long hardware reset ends, and the settings decoded from them are then held until the next such reset. The settings are: the management address, the isolate flag, the choice between the four-bit and the two-bit MAC data interface, whether the two-bit interface sources its own reference clock, fiber operation, auto-negotiation, forced speed and duplex, advertised abilities, indicator-light mode, clock-output enable and control-frame response enable.

The raw active-low reset pin passes through a width filter that counts reference-clock edges. A low pulse shorter than the limit is ignored. A qualified reset drives `dev_rst` high for the rest of the device. After reset, management logic may overwrite the live address. A software reset puts the live address back to the strapped value kept in storage, and does not read the pins again.

Top module: `rst_strap_cfg`

## Requirements
- R1: Before the first qualified reset the outputs show the pull-resistor defaults: `phy_addr`=1, `isolate`=0, `aneg_en`=1, `adv_abil`=4'b1111, `led_mode`=1, `rmii_mode`=0, `rmii_master`=0, `fiber_mode`=0, `clkout_en`=0, `ctlfrm_en`=0, `dev_rst`=0.
- R2: `dev_rst` rises on the clock edge at which `hw_rst_n` has been sampled low on MIN_LOW_CYC consecutive edges. It falls on the first edge at which `hw_rst_n` is sampled high. A shorter low pulse changes no output.
- R3: All strap pins are captured on the edge where `dev_rst` is high and `hw_rst_n` is sampled high. Pin changes at any other time have no effect on the outputs.
- R4: `isolate` is 1 exactly when the captured strap address is 0. Writing address 0 through `addr_wr_en` leaves `isolate` unchanged.
- R5: When `addr_wr_en` is high and `dev_rst` is low, `phy_addr` takes `addr_wr_data` on the next edge.
- R6: When `sw_rst` is high and `dev_rst` is low, `phy_addr` returns to the stored strapped address on the next edge, even if the pins have changed. `sw_rst` wins over a write in the same cycle.
- R7: With `strap_fx_n`=1 and `strap_an_en`=0, `aneg_en`=0, `adv_abil`=0, `force_100`=`strap_an1` and `force_full`=`strap_an0`.
- R8: With `strap_fx_n`=1 and `strap_an_en`=1, `aneg_en`=1 and `force_100`=`force_full`=0. `adv_abil` bits are {100 full, 100 half, 10 full, 10 half}, and {an1,an0} selects 00→0011, 01→1100, 10→1000, 11→1111.
- R9: With `strap_fx_n`=0, `fiber_mode`=1, `aneg_en`=0, `adv_abil`=0 and `force_100`=1. `force_full`=`strap_an0`, and `strap_an_en` and `strap_an1` are ignored.
- R10: `rmii_mode`=`strap_rmii`. `rmii_master` is 1 only when both `strap_rmii` and `strap_rmii_mst` were captured high.
- R11: `led_mode` is 1 when `strap_led` is 0 and 2 when it is 1. `clkout_en` and `ctlfrm_en` follow their captured straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| hw_rst_n | input | 1 | Raw hardware reset pin, active low |
| sw_rst | input | 1 | Software reset request, active high |
| addr_wr_en | input | 1 | Live address write strobe |
| addr_wr_data | input | ADDR_W | Live address write value |
| strap_addr | input | ADDR_W | Address strap pins |
| strap_an_en | input | 1 | Auto-negotiation enable strap |
| strap_an1 | input | 1 | Mode strap bit 1 |
| strap_an0 | input | 1 | Mode strap bit 0 |
| strap_fx_n | input | 1 | Fiber select strap, active low |
| strap_rmii | input | 1 | Two-bit MAC interface strap |
| strap_rmii_mst | input | 1 | Reference-clock master strap |
| strap_led | input | 1 | Indicator mode strap |
| strap_clkout | input | 1 | Clock output enable strap |
| strap_ctlfrm | input | 1 | Control-frame enable strap |
| dev_rst | output | 1 | Qualified device reset, active high |
| phy_addr | output | ADDR_W | Live management address |
| isolate | output | 1 | Isolate mode |
| rmii_mode | output | 1 | Two-bit MAC interface selected |
| rmii_master | output | 1 | Block sources reference clock |
| fiber_mode | output | 1 | Fiber operation |
| aneg_en | output | 1 | Auto-negotiation enabled |
| force_100 | output | 1 | Forced 100 Mb/s |
| force_full | output | 1 | Forced full duplex |
| adv_abil | output | 4 | Advertised abilities |
| led_mode | output | 2 | Indicator mode (1 or 2) |
| clkout_en | output | 1 | Clock output enabled |
| ctlfrm_en | output | 1 | Control-frame response enabled |

## Verification
The bench builds the block with MIN_LOW_CYC=6 and ADDR_W=5. The short filter limit lets pulses of exactly MIN_LOW_CYC-1 and MIN_LOW_CYC edges be tried many times within the cycle budget, so both sides of the filter boundary are hit. The five-bit address lets the bench reach address 0 and compare write-zero with strap-zero, and it also covers all sixteen mode-pin combinations.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int ADV_W = 4;

  typedef enum logic [1:0] {
    LED_M1 = 2'd1,
    LED_M2 = 2'd2
  } led_mode_e;

  typedef struct packed {
    logic              iso;
    logic              rmii;
    logic              rmii_mst;
    logic              fiber;
    logic              aneg;
    logic              f100;
    logic              ffull;
    logic [ADV_W-1:0]  adv;
    led_mode_e         led;
    logic              clkout;
    logic              ctlfrm;
  } cfg_t;

  // power-up settings, matching the pull resistors on the pins
  function automatic cfg_t cfg_default();
    cfg_t c;
    c.iso      = 1'b0;
    c.rmii     = 1'b0;
    c.rmii_mst = 1'b0;
    c.fiber    = 1'b0;
    c.aneg     = 1'b1;
    c.f100     = 1'b0;
    c.ffull    = 1'b0;
    c.adv      = '1;
    c.led      = LED_M1;
    c.clkout   = 1'b0;
    c.ctlfrm   = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/rst_width_filter.sv
module rst_width_filter #(
  parameter int MIN_LOW_CYC = 25
) (
  input  logic clk,
  input  logic rst_pin_n,
  output logic held,
  output logic release_p
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] LIM    = CW'(MIN_LOW_CYC);
  localparam logic [CW-1:0] LIM_M1 = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] low_cnt = '0;
  logic          held_q  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst_pin_n)
      low_cnt <= '0;
    else if (low_cnt != LIM)
      low_cnt <= low_cnt + 1'b1;
    held_q <= !rst_pin_n && (low_cnt >= LIM_M1);
  end

  assign held      = held_q;
  assign release_p = held_q && rst_pin_n;
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic              pin_an_en,
  input  logic              pin_an1,
  input  logic              pin_an0,
  input  logic              pin_fx_n,
  input  logic              pin_rmii,
  input  logic              pin_rmii_mst,
  input  logic              pin_led,
  input  logic              pin_clkout,
  input  logic              pin_ctlfrm,
  output cfg_t              cfg
);
  logic fiber, aneg;

  always_comb begin
    fiber = !pin_fx_n;
    aneg  = pin_fx_n && pin_an_en;

    cfg.iso      = (pin_addr == '0);
    cfg.rmii     = pin_rmii;
    cfg.rmii_mst = pin_rmii && pin_rmii_mst;
    cfg.fiber    = fiber;
    cfg.aneg     = aneg;
    cfg.f100     = fiber ? 1'b1 : (aneg ? 1'b0 : pin_an1);
    cfg.ffull    = aneg ? 1'b0 : pin_an0;
    cfg.adv      = '0;
    if (aneg) begin
      unique case ({pin_an1, pin_an0})
        2'b00:   cfg.adv = 4'b0011;
        2'b01:   cfg.adv = 4'b1100;
        2'b10:   cfg.adv = 4'b1000;
        default: cfg.adv = 4'b1111;
      endcase
    end
    cfg.led    = pin_led ? LED_M2 : LED_M1;
    cfg.clkout = pin_clkout;
    cfg.ctlfrm = pin_ctlfrm;
  end
endmodule

// File: rtl/strap_hold.sv
module strap_hold
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              capture,
  input  logic              in_rst,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] pin_addr,
  input  cfg_t              cfg_in,
  output logic [ADDR_W-1:0] live_addr,
  output cfg_t              cfg_q
);
  localparam logic [ADDR_W-1:0] DEF_ADDR = ADDR_W'(1);

  logic [ADDR_W-1:0] saved_addr = DEF_ADDR;
  logic [ADDR_W-1:0] addr_q     = DEF_ADDR;
  cfg_t              cfg_r      = cfg_default();

  always_ff @(posedge clk) begin
    if (capture) begin
      saved_addr <= pin_addr;
      addr_q     <= pin_addr;
      cfg_r      <= cfg_in;
    end else if (!in_rst) begin
      if (sw_rst)
        addr_q <= saved_addr;
      else if (wr_en)
        addr_q <= wr_addr;
    end
  end

  assign live_addr = addr_q;
  assign cfg_q     = cfg_r;
endmodule

// File: rtl/rst_strap_cfg.sv
module rst_strap_cfg
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int MIN_LOW_CYC = 25
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              sw_rst,
  input  logic              addr_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_data,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_an_en,
  input  logic              strap_an1,
  input  logic              strap_an0,
  input  logic              strap_fx_n,
  input  logic              strap_rmii,
  input  logic              strap_rmii_mst,
  input  logic              strap_led,
  input  logic              strap_clkout,
  input  logic              strap_ctlfrm,
  output logic              dev_rst,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              isolate,
  output logic              rmii_mode,
  output logic              rmii_master,
  output logic              fiber_mode,
  output logic              aneg_en,
  output logic              force_100,
  output logic              force_full,
  output logic [3:0]        adv_abil,
  output logic [1:0]        led_mode,
  output logic              clkout_en,
  output logic              ctlfrm_en
);
  logic release_p;
  cfg_t cfg_dec, cfg_now;

  rst_width_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filt (
    .clk       (clk),
    .rst_pin_n (hw_rst_n),
    .held      (dev_rst),
    .release_p (release_p)
  );

  strap_decode #(.ADDR_W(ADDR_W)) u_dec (
    .pin_addr     (strap_addr),
    .pin_an_en    (strap_an_en),
    .pin_an1      (strap_an1),
    .pin_an0      (strap_an0),
    .pin_fx_n     (strap_fx_n),
    .pin_rmii     (strap_rmii),
    .pin_rmii_mst (strap_rmii_mst),
    .pin_led      (strap_led),
    .pin_clkout   (strap_clkout),
    .pin_ctlfrm   (strap_ctlfrm),
    .cfg          (cfg_dec)
  );

  strap_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk       (clk),
    .capture   (release_p),
    .in_rst    (dev_rst),
    .sw_rst    (sw_rst),
    .wr_en     (addr_wr_en),
    .wr_addr   (addr_wr_data),
    .pin_addr  (strap_addr),
    .cfg_in    (cfg_dec),
    .live_addr (phy_addr),
    .cfg_q     (cfg_now)
  );

  assign isolate     = cfg_now.iso;
  assign rmii_mode   = cfg_now.rmii;
  assign rmii_master = cfg_now.rmii_mst;
  assign fiber_mode  = cfg_now.fiber;
  assign aneg_en     = cfg_now.aneg;
  assign force_100   = cfg_now.f100;
  assign force_full  = cfg_now.ffull;
  assign adv_abil    = cfg_now.adv;
  assign led_mode    = cfg_now.led;
  assign clkout_en   = cfg_now.clkout;
  assign ctlfrm_en   = cfg_now.ctlfrm;
endmodule

// File: rtl/rst_strap_cfg_chk.sv
module rst_strap_cfg_chk (
  input logic       clk,
  input logic       hw_rst_n,
  input logic       dev_rst,
  input logic       isolate,
  input logic       rmii_mode,
  input logic       rmii_master,
  input logic       fiber_mode,
  input logic       aneg_en,
  input logic       force_100,
  input logic [3:0] adv_abil,
  input logic [1:0] led_mode
);
  // R2
  rel_on_high_chk: assert property (@(posedge clk) disable iff (dev_rst)
    hw_rst_n |=> !dev_rst);

  // R2
  rise_needs_low_chk: assert property (@(posedge clk)
    $rose(dev_rst) |-> !$past(hw_rst_n));

  // R4
  iso_hold_chk: assert property (@(posedge clk) disable iff (dev_rst)
    !$past(dev_rst) |-> $stable(isolate));

  // R10
  mst_gate_chk: assert property (@(posedge clk) disable iff (dev_rst)
    rmii_master |-> rmii_mode);

  // R9
  fiber_cfg_chk: assert property (@(posedge clk) disable iff (dev_rst)
    fiber_mode |-> (!aneg_en && force_100 && adv_abil == 4'b0000));

  // R8
  aneg_adv_chk: assert property (@(posedge clk) disable iff (dev_rst)
    aneg_en |-> (adv_abil != 4'b0000 && $countones(adv_abil) != 3));

  // R11
  led_range_chk: assert property (@(posedge clk) disable iff (dev_rst)
    $onehot0(led_mode) && led_mode != 2'd0);
endmodule

bind rst_strap_cfg rst_strap_cfg_chk u_chk (.*);

// File: tb/rst_strap_cfg_tb.sv
module rst_strap_cfg_tb;
  localparam int AW  = 5;
  localparam int MIN = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic hw_rst_n = 1'b1, sw_rst = 1'b0, addr_wr_en = 1'b0;
  logic [AW-1:0] addr_wr_data = '0, strap_addr = '0;
  logic strap_an_en = 0, strap_an1 = 0, strap_an0 = 0, strap_fx_n = 1;
  logic strap_rmii = 0, strap_rmii_mst = 0, strap_led = 0, strap_clkout = 0, strap_ctlfrm = 0;
  logic dev_rst, isolate, rmii_mode, rmii_master, fiber_mode, aneg_en, force_100, force_full;
  logic clkout_en, ctlfrm_en;
  logic [AW-1:0] phy_addr;
  logic [3:0] adv_abil;
  logic [1:0] led_mode;

  int errs = 0, checks = 0;
  // captured pin copies
  logic [AW-1:0] c_addr = AW'(1);
  logic [9:0] c_pins = {1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};

  rst_strap_cfg #(.ADDR_W(AW), .MIN_LOW_CYC(MIN)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_adv(input logic [9:0] p);
    // p = {an_en, an1, an0, fx_n, rmii, mst, led, clkout, ctlfrm, unused}
    if (!(p[9] && p[6])) return 4'b0000;
    case (p[8:7])
      2'b00: return 4'b0011;
      2'b01: return 4'b1100;
      2'b10: return 4'b1000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [9:0] live_pins();
    return {strap_an_en, strap_an1, strap_an0, strap_fx_n, strap_rmii,
            strap_rmii_mst, strap_led, strap_clkout, strap_ctlfrm, 1'b0};
  endfunction

  task automatic check_cfg(input string tag);
    logic fib, an;
    fib = !c_pins[6];
    an  = c_pins[6] && c_pins[9];
    chk({tag, " R4 isolate"}, isolate, (c_addr == 0));
    chk({tag, " R9 fiber"}, fiber_mode, fib);
    chk({tag, " R7/R8 aneg"}, aneg_en, an);
    chk({tag, " R8 adv"}, adv_abil, exp_adv(c_pins));
    chk({tag, " R7 f100"}, force_100, fib ? 1 : (an ? 0 : c_pins[8]));
    chk({tag, " R7 ffull"}, force_full, an ? 0 : c_pins[7]);
    chk({tag, " R10 rmii"}, rmii_mode, c_pins[5]);
    chk({tag, " R10 mst"}, rmii_master, c_pins[5] && c_pins[4]);
    chk({tag, " R11 led"}, led_mode, c_pins[3] ? 2 : 1);
    chk({tag, " R11 clkout"}, clkout_en, c_pins[2]);
    chk({tag, " R11 ctlfrm"}, ctlfrm_en, c_pins[1]);
  endtask

  task automatic set_pins(input logic [AW-1:0] a, input logic [8:0] v);
    strap_addr = a;
    {strap_an_en, strap_an1, strap_an0, strap_fx_n, strap_rmii,
     strap_rmii_mst, strap_led, strap_clkout, strap_ctlfrm} = v;
  endtask

  task automatic hw_pulse(input int n);
    @(negedge clk); hw_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    chk("R2 dev_rst before release", dev_rst, (n >= MIN));
    hw_rst_n = 1'b1;
    if (n >= MIN) begin c_addr = strap_addr; c_pins = live_pins(); end
    @(negedge clk);
    chk("R2 dev_rst after release", dev_rst, 0);
  endtask

  task automatic cyc(input logic s, input logic w, input logic [AW-1:0] d);
    sw_rst = s; addr_wr_en = w; addr_wr_data = d;
    @(negedge clk);
    sw_rst = 0; addr_wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 defaults
    chk("R1 addr", phy_addr, 1);
    chk("R1 dev_rst", dev_rst, 0);
    check_cfg("R1");

    // R2 short pulse ignored
    set_pins(5'd0, 9'b0_0_1_0_1_1_1_1_1);
    hw_pulse(MIN - 1);
    chk("R2 short addr", phy_addr, 1);
    check_cfg("R2 short");

    // R3/R4 qualified reset with strapped zero address
    hw_pulse(MIN);
    chk("R3 addr", phy_addr, 0);
    check_cfg("R3 zero");
    set_pins(5'd7, 9'b1_1_1_1_0_0_0_0_0);
    repeat (3) @(negedge clk);
    chk("R3 held addr", phy_addr, 0);
    check_cfg("R3 held");

    // R4/R5/R6 address override and software reload
    set_pins(5'd9, 9'b1_0_1_1_0_0_0_0_0);
    hw_pulse(MIN + 2);
    cyc(0, 1, 5'd0);
    chk("R5 write zero", phy_addr, 0);
    chk("R4 no isolate on write", isolate, 0);
    cyc(0, 1, 5'd22);
    chk("R5 write 22", phy_addr, 22);
    strap_addr = 5'd3;
    cyc(1, 0, 5'd0);
    chk("R6 reload", phy_addr, 9);
    cyc(0, 1, 5'd17);
    cyc(1, 1, 5'd30);
    chk("R6 sw over write", phy_addr, 9);

    // R7/R8/R9 every mode-pin combination, plus R10 gating
    for (int k = 0; k < 16; k++) begin
      set_pins(5'd4, {k[3:0], k[1], k[0], 3'b000});
      hw_pulse(MIN);
      check_cfg("R7/R8/R9 sweep");
    end

    // random mix
    for (int i = 0; i < 40; i++) begin
      set_pins(AW'($urandom), 9'($urandom));
      hw_pulse(MIN + int'($urandom % 3));
      chk("R3 rand addr", phy_addr, c_addr);
      check_cfg("rand");
      set_pins(AW'($urandom), 9'($urandom));
      if ($urandom % 2 == 1) hw_pulse(1 + int'($urandom % (MIN - 1)));
      repeat (2) @(negedge clk);
      chk("R2/R3 rand hold", phy_addr, c_addr);
      check_cfg("rand hold");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule